// File: doc/BRIEF.md
# Stacked Asynchronous SRAM Controller

This block sits between a synchronous host and a memory module made of eight byte-wide asynchronous static RAMs. The RAMs form two banks of four byte lanes. All eight share one 19-bit address bus, one 32-bit data bus and common write and output strobes, and each RAM has its own active-low select. The host sees one 22-bit byte-style address space. It can use that space as one million 32-bit words, two million 16-bit halves or four million bytes, and it picks the width on each request.

A request is held high on `host_req` until the controller returns a one-cycle `host_ack`. Each access is translated into a memory address and a select pattern, and data is steered onto the byte lanes. The controller then drives the strobes for whole numbers of clock cycles, which come from nanosecond parameters rounded up against the clock period. Writes are framed so that the address settles while every strobe is high and is still unchanged when the strobes rise again. Reads end with a period of silence on the bus, so the RAMs let go of the data lines before the controller drives them again. The data bus is split into an output value, an output enable and an input value, for a pad ring that supplies the tri-state buffer.

Top module: `sram_stack_ctrl`

## Requirements
- R1: During and right after reset, all eight selects, the write strobe and the output strobe are high, the data driver is off and `host_ack` is low.
- R2: Width code 2'b10 is 32-bit mode. Host bit 19 picks the bank (0: selects 0..3, 1: selects 4..7), all four selects of that bank go low, and host bits 18:0 form the memory address.
- R3: Width code 2'b01 is 16-bit mode. Host bit 0 picks lanes 0 and 1 (value 0) or lanes 2 and 3 (value 1), host bit 20 picks the bank, and host bits 19:1 form the memory address. Exactly two selects go low.
- R4: Width code 2'b00 is 8-bit mode. Host bits 1:0 pick the lane, host bit 21 picks the bank, and host bits 20:2 form the memory address. Exactly one select goes low.
- R5: In the narrow modes, the low 8 or 16 bits of the write data are repeated across the whole 32-bit data bus.
- R6: Narrow read data comes from the selected lanes and is placed at bit 0 of `host_rdata`, with zeros above it. A 32-bit read returns lane k in bits 8k+7:8k.
- R7: The memory address never changes in a cycle where, before or after the change, a select and the write strobe are low together. The address is set one setup cycle before the write strobes fall.
- R8: A write keeps its selects and the write strobe low together for the parameterised pulse length: one cycle with the default 20 ns clock. The data driver is on during the whole pulse.
- R9: The data driver is never on while the output strobe is low. At least one cycle with the bus undriven and the output strobe high separates a read from the next write drive.
- R10: A read holds its selects and the output strobe low, with the write strobe high, for the parameterised read length: one cycle by default. The bus value is captured at the end of it.
- R11: `host_ack` is high for exactly one cycle per request. Each request produces one memory access and one acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req | input | 1 | Request, held until acknowledged |
| host_write | input | 1 | 1 = write, 0 = read |
| host_width | input | 2 | 00 byte, 01 half, 10 word |
| host_addr | input | 22 | Host address |
| host_wdata | input | 32 | Write data, right-justified |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read data, valid with the acknowledge |
| mem_addr | output | 19 | Shared memory address |
| mem_cs_n | output | 8 | Selects; bits 3:0 bank 0, bits 7:4 bank 1, bit index within bank = lane |
| mem_we_n | output | 1 | Common write strobe |
| mem_oe_n | output | 1 | Common output strobe |
| mem_dq_o | output | 32 | Data to drive onto the bus |
| mem_dq_oe | output | 1 | Bus driver enable |
| mem_dq_i | input | 32 | Data sampled from the bus |

## Verification
The properties check on every cycle that the address stays still while a write is in flight, that select patterns never span both banks and never have three lanes low, that a write never happens without the driver on, that the driver and the output strobe are never on together, and that the acknowledge is a single pulse. Only the scenarios can show that each host address lands on the right memory address and lanes in each width, that narrow data is replicated on the way out and right-justified on the way back, and that pulse lengths and the gap between a read and a following write match the cycle counts the timing parameters imply. Those scenarios check data round trips against a small model of the RAMs.

// File: rtl/sram_stack_pkg.sv
package sram_stack_pkg;

    localparam int LANES  = 4;
    localparam int BANKS  = 2;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;
    localparam int NCS    = LANES * BANKS;

    typedef enum logic [1:0] {
        WID_8  = 2'b00,
        WID_16 = 2'b01,
        WID_32 = 2'b10
    } width_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WSETUP,
        S_WPULSE,
        S_WRECOV,
        S_RACT,
        S_RHIZ
    } state_e;

    // whole cycles covering t_ns, never fewer than one
    function automatic int cyc_of(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/sram_lane_map.sv
module sram_lane_map
    import sram_stack_pkg::*;
#(
    parameter int ADDR_W = 19,
    localparam int HA_W  = ADDR_W + 3
) (
    input  width_e              width,
    input  logic [HA_W-1:0]     haddr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [ADDR_W-1:0]   maddr,
    output logic [NCS-1:0]      cs_mask,
    output logic [DATA_W-1:0]   wbus,
    output logic [1:0]          lane
);
    logic [LANES-1:0] lmask;
    logic             bank;

    always_comb begin
        case (width)
            WID_8: begin
                lane  = haddr[1:0];
                maddr = haddr[ADDR_W+1:2];
                bank  = haddr[ADDR_W+2];
                lmask = LANES'(1) << haddr[1:0];
                wbus  = {LANES{wdata[LANE_W-1:0]}};
            end
            WID_16: begin
                lane  = {haddr[0], 1'b0};
                maddr = haddr[ADDR_W:1];
                bank  = haddr[ADDR_W+1];
                lmask = haddr[0] ? 4'b1100 : 4'b0011;
                wbus  = {2{wdata[2*LANE_W-1:0]}};
            end
            default: begin
                lane  = 2'd0;
                maddr = haddr[ADDR_W-1:0];
                bank  = haddr[ADDR_W];
                lmask = '1;
                wbus  = wdata;
            end
        endcase
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        assign cs_mask[b*LANES +: LANES] = (int'(bank) == b) ? lmask : '0;
    end

endmodule

// File: rtl/sram_rd_align.sv
module sram_rd_align
    import sram_stack_pkg::*;
(
    input  width_e             width,
    input  logic [1:0]         lane,
    input  logic [DATA_W-1:0]  bus,
    output logic [DATA_W-1:0]  data
);
    always_comb begin
        case (width)
            WID_8:   data = {{(DATA_W-LANE_W){1'b0}}, bus[lane*LANE_W +: LANE_W]};
            WID_16:  data = {{(DATA_W-2*LANE_W){1'b0}}, bus[lane*LANE_W +: 2*LANE_W]};
            default: data = bus;
        endcase
    end
endmodule

// File: rtl/sram_seq.sv
module sram_seq
    import sram_stack_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int SU_CYC = 1,
    parameter int PW_CYC = 1,
    parameter int WR_CYC = 1,
    parameter int RD_CYC = 1,
    parameter int TA_CYC = 1,
    localparam int CW    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               wr,
    input  width_e             width,
    input  logic [1:0]         lane,
    input  logic [ADDR_W-1:0]  maddr,
    input  logic [NCS-1:0]     cs_mask,
    input  logic [DATA_W-1:0]  wbus,
    input  logic [DATA_W-1:0]  rd_aligned,
    output width_e             cur_width,
    output logic [1:0]         cur_lane,
    output logic               ack,
    output logic [DATA_W-1:0]  rdata,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [NCS-1:0]     mem_cs_n,
    output logic               mem_we_n,
    output logic               mem_oe_n,
    output logic [DATA_W-1:0]  mem_dq_o,
    output logic               mem_dq_oe
);
    localparam logic [CW-1:0] SU_L = CW'(SU_CYC - 1);
    localparam logic [CW-1:0] PW_L = CW'(PW_CYC - 1);
    localparam logic [CW-1:0] WR_L = CW'(WR_CYC - 1);
    localparam logic [CW-1:0] RD_L = CW'(RD_CYC - 1);
    localparam logic [CW-1:0] TA_L = CW'(TA_CYC - 1);

    typedef struct packed {
        state_e              st;
        logic [CW-1:0]       cnt;
        logic [ADDR_W-1:0]   addr;
        logic [NCS-1:0]      pat;
        logic [NCS-1:0]      cs_n;
        logic                we_n;
        logic                oe_n;
        logic                dq_oe;
        logic [DATA_W-1:0]   wbus;
        logic [DATA_W-1:0]   rdata;
        logic                ack;
        width_e              width;
        logic [1:0]          lane;
    } seq_t;

    localparam seq_t RST = '{st: S_IDLE, cnt: '0, addr: '0, pat: '0, cs_n: '1,
                             we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0, wbus: '0,
                             rdata: '0, ack: 1'b0, width: WID_32, lane: 2'd0};

    seq_t q, d;

    always_comb begin
        d     = q;
        d.ack = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (req && !q.ack) begin
                    d.addr  = maddr;
                    d.pat   = cs_mask;
                    d.wbus  = wbus;
                    d.width = width;
                    d.lane  = lane;
                    if (wr) begin
                        d.st    = S_WSETUP;
                        d.dq_oe = 1'b1;
                        d.cnt   = SU_L;
                    end else begin
                        d.st   = S_RACT;
                        d.cs_n = ~cs_mask;
                        d.oe_n = 1'b0;
                        d.cnt  = RD_L;
                    end
                end
            end
            S_WSETUP: begin
                if (q.cnt == '0) begin
                    d.st   = S_WPULSE;
                    d.cs_n = ~q.pat;
                    d.we_n = 1'b0;
                    d.cnt  = PW_L;
                end else d.cnt = q.cnt - 1'b1;
            end
            S_WPULSE: begin
                if (q.cnt == '0) begin
                    d.st   = S_WRECOV;
                    d.cs_n = '1;
                    d.we_n = 1'b1;
                    d.cnt  = WR_L;
                end else d.cnt = q.cnt - 1'b1;
            end
            S_WRECOV: begin
                if (q.cnt == '0) begin
                    d.st    = S_IDLE;
                    d.dq_oe = 1'b0;
                    d.ack   = 1'b1;
                end else d.cnt = q.cnt - 1'b1;
            end
            S_RACT: begin
                if (q.cnt == '0) begin
                    d.st    = S_RHIZ;
                    d.rdata = rd_aligned;
                    d.cs_n  = '1;
                    d.oe_n  = 1'b1;
                    d.cnt   = TA_L;
                end else d.cnt = q.cnt - 1'b1;
            end
            S_RHIZ: begin
                if (q.cnt == '0) begin
                    d.st  = S_IDLE;
                    d.ack = 1'b1;
                end else d.cnt = q.cnt - 1'b1;
            end
            default: d = RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST;
        else        q <= d;
    end

    assign cur_width = q.width;
    assign cur_lane  = q.lane;
    assign ack       = q.ack;
    assign rdata     = q.rdata;
    assign mem_addr  = q.addr;
    assign mem_cs_n  = q.cs_n;
    assign mem_we_n  = q.we_n;
    assign mem_oe_n  = q.oe_n;
    assign mem_dq_o  = q.wbus;
    assign mem_dq_oe = q.dq_oe;

    AST_ADDR_HELD_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.we_n && !(&q.cs_n)) |-> $stable(q.addr)); // R7
    AST_STROBE_HIGH_ON_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.addr) |-> ((q.we_n || &q.cs_n) && ($past(q.we_n) || &$past(q.cs_n)))); // R7
    AST_SINGLE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (&q.cs_n[NCS-1:LANES]) || (&q.cs_n[LANES-1:0])); // R2
    AST_LANE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~q.cs_n) != 3); // R3
    AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !q.we_n |-> q.dq_oe); // R8
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        q.dq_oe |-> q.oe_n); // R9
    AST_DRIVE_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.dq_oe) |-> $past(q.oe_n)); // R9
    AST_READ_WE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !q.oe_n |-> q.we_n); // R10
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        q.ack |=> !q.ack); // R11

endmodule

// File: rtl/sram_stack_ctrl.sv
module sram_stack_ctrl
    import sram_stack_pkg::*;
#(
    parameter int ADDR_W  = 19,
    parameter int CLK_NS  = 20,
    parameter int T_AS_NS = 0,
    parameter int T_WP_NS = 10,
    parameter int T_CW_NS = 10,
    parameter int T_DW_NS = 6,
    parameter int T_WR_NS = 0,
    parameter int T_RC_NS = 12,
    parameter int T_HZ_NS = 6,
    localparam int HA_W   = ADDR_W + 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_req,
    input  logic               host_write,
    input  logic [1:0]         host_width,
    input  logic [HA_W-1:0]    host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic               host_ack,
    output logic [DATA_W-1:0]  host_rdata,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [NCS-1:0]     mem_cs_n,
    output logic               mem_we_n,
    output logic               mem_oe_n,
    output logic [DATA_W-1:0]  mem_dq_o,
    output logic               mem_dq_oe,
    input  logic [DATA_W-1:0]  mem_dq_i
);
    localparam int C_WP   = cyc_of(T_WP_NS, CLK_NS);
    localparam int C_CW   = cyc_of(T_CW_NS, CLK_NS);
    localparam int C_DW   = cyc_of(T_DW_NS, CLK_NS);
    localparam int C_PW0  = (C_WP > C_CW) ? C_WP : C_CW;
    localparam int PW_CYC = (C_PW0 > C_DW) ? C_PW0 : C_DW;
    localparam int SU_CYC = cyc_of(T_AS_NS, CLK_NS);
    localparam int WR_CYC = cyc_of(T_WR_NS, CLK_NS);
    localparam int RD_CYC = cyc_of(T_RC_NS, CLK_NS);
    localparam int TA_CYC = cyc_of(T_HZ_NS, CLK_NS);

    logic [ADDR_W-1:0] map_addr;
    logic [NCS-1:0]    map_cs;
    logic [DATA_W-1:0] map_wbus;
    logic [1:0]        map_lane;
    logic [DATA_W-1:0] rd_aligned;
    width_e            cur_width;
    logic [1:0]        cur_lane;

    sram_lane_map #(.ADDR_W(ADDR_W)) u_map (
        .width   (width_e'(host_width)),
        .haddr   (host_addr),
        .wdata   (host_wdata),
        .maddr   (map_addr),
        .cs_mask (map_cs),
        .wbus    (map_wbus),
        .lane    (map_lane)
    );

    sram_rd_align u_align (
        .width (cur_width),
        .lane  (cur_lane),
        .bus   (mem_dq_i),
        .data  (rd_aligned)
    );

    sram_seq #(
        .ADDR_W (ADDR_W),
        .SU_CYC (SU_CYC),
        .PW_CYC (PW_CYC),
        .WR_CYC (WR_CYC),
        .RD_CYC (RD_CYC),
        .TA_CYC (TA_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (host_req),
        .wr         (host_write),
        .width      (width_e'(host_width)),
        .lane       (map_lane),
        .maddr      (map_addr),
        .cs_mask    (map_cs),
        .wbus       (map_wbus),
        .rd_aligned (rd_aligned),
        .cur_width  (cur_width),
        .cur_lane   (cur_lane),
        .ack        (host_ack),
        .rdata      (host_rdata),
        .mem_addr   (mem_addr),
        .mem_cs_n   (mem_cs_n),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_dq_o   (mem_dq_o),
        .mem_dq_oe  (mem_dq_oe)
    );

endmodule

// File: tb/sram_stack_ctrl_test.sv
module sram_stack_ctrl_test;

    localparam int EXP_PW = 1;  // max(ceil(10/20), ceil(6/20)) cycles
    localparam int EXP_RD = 1;  // ceil(12/20) cycles

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_write = 1'b0;
    logic [1:0]  host_width = 2'b10;
    logic [21:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        host_ack;
    logic [31:0] host_rdata;
    logic [18:0] mem_addr;
    logic [7:0]  mem_cs_n;
    logic        mem_we_n, mem_oe_n, mem_dq_oe;
    logic [31:0] mem_dq_o;
    logic [31:0] mem_dq_i;

    always #10 clk = ~clk;

    sram_stack_ctrl uut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_write(host_write),
        .host_width(host_width), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_ack(host_ack), .host_rdata(host_rdata), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // behavioural RAM stub: 8 devices, 64 bytes each
    logic [7:0] stub [8][64];
    always_comb begin
        mem_dq_i = 32'h0;
        if (!mem_oe_n && mem_we_n)
            for (int k = 0; k < 8; k++)
                if (!mem_cs_n[k]) mem_dq_i[(k%4)*8 +: 8] = stub[k][mem_addr[5:0]];
    end
    always @(posedge clk)
        if (!mem_we_n)
            for (int k = 0; k < 8; k++)
                if (!mem_cs_n[k]) stub[k][mem_addr[5:0]] <= mem_dq_o[(k%4)*8 +: 8];

    int checks = 0;
    int fails  = 0;

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] f_cs_n(logic [1:0] w, logic [21:0] a);
        logic [3:0] lm;
        logic b;
        case (w)
            2'b00:   begin lm = 4'b0001 << a[1:0]; b = a[21]; end
            2'b01:   begin lm = a[0] ? 4'b1100 : 4'b0011; b = a[20]; end
            default: begin lm = 4'b1111; b = a[19]; end
        endcase
        return b ? ~{lm, 4'b0000} : ~{4'b0000, lm};
    endfunction

    function automatic logic [18:0] f_maddr(logic [1:0] w, logic [21:0] a);
        case (w)
            2'b00:   return a[20:2];
            2'b01:   return a[19:1];
            default: return a[18:0];
        endcase
    endfunction

    function automatic logic [31:0] f_bus(logic [1:0] w, logic [31:0] d);
        case (w)
            2'b00:   return {d[7:0], d[7:0], d[7:0], d[7:0]};
            2'b01:   return {d[15:0], d[15:0]};
            default: return d;
        endcase
    endfunction

    typedef struct {
        bit          rd;
        logic [7:0]  cs_n;
        logic [18:0] maddr;
        logic [31:0] bus;
        logic [31:0] rdata;
        string       tag;
    } exp_t;

    exp_t sb[$];
    logic [7:0] model [8][64];

    task automatic do_op(bit wr, logic [1:0] w, logic [21:0] a, logic [31:0] d, string tag);
        exp_t e;
        logic [31:0] word;
        logic [5:0] m;
        e.rd    = !wr;
        e.cs_n  = f_cs_n(w, a);
        e.maddr = f_maddr(w, a);
        e.bus   = f_bus(w, d);
        e.tag   = tag;
        e.rdata = '0;
        m = e.maddr[5:0];
        word = '0;
        for (int k = 0; k < 8; k++)
            if (!e.cs_n[k]) begin
                if (wr) model[k][m] = e.bus[(k%4)*8 +: 8];
                word[(k%4)*8 +: 8] = model[k][m];
            end
        case (w)
            2'b00:   e.rdata = {24'h0, word[a[1:0]*8 +: 8]};
            2'b01:   e.rdata = a[0] ? {16'h0, word[31:16]} : {16'h0, word[15:0]};
            default: e.rdata = word;
        endcase
        sb.push_back(e);
        @(negedge clk);
        host_req = 1'b1; host_write = wr; host_width = w; host_addr = a; host_wdata = d;
        do @(negedge clk); while (!host_ack);
        host_req = 1'b0;
        @(negedge clk);
        check("R11", "ack one cycle", {31'h0, host_ack}, 32'h0);
    endtask

    // monitor: scoreboard and per-cycle pin rules
    logic        prev_idle = 1'b1;
    logic [18:0] pa = '0;
    logic        pws = 1'b0, pdq = 1'b0;
    int viol_addr = 0, viol_drive = 0, pw_cnt = 0, oe_cnt = 0, gap = 0;
    bit saw_read = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            logic ws;
            ws = !mem_we_n && !(&mem_cs_n);
            if (!(&mem_cs_n) && prev_idle) begin
                if (sb.size() == 0) check("R11", "access without request", 32'h1, 32'h0);
                else begin
                    check(sb[0].tag, "selects", {24'h0, mem_cs_n}, {24'h0, sb[0].cs_n});
                    check(sb[0].tag, "mem address", {13'h0, mem_addr}, {13'h0, sb[0].maddr});
                    if (!sb[0].rd) check("R5", "write bus", mem_dq_o, sb[0].bus);
                    else check("R10", "we high in read", {31'h0, mem_we_n}, 32'h1);
                end
            end
            if (host_ack) begin
                if (sb.size() == 0) check("R11", "spurious ack", 32'h1, 32'h0);
                else begin
                    if (sb[0].rd) check("R6", "read data", host_rdata, sb[0].rdata);
                    void'(sb.pop_front());
                end
            end
            if (mem_addr != pa && (ws || pws)) viol_addr++;          // R7
            if (mem_dq_oe && !mem_oe_n) viol_drive++;                // R9
            if (ws && !mem_dq_oe) viol_drive++;                      // R8
            if (!mem_we_n) pw_cnt++;
            else if (pw_cnt > 0) begin
                check("R8", "write pulse cycles", pw_cnt, EXP_PW);
                pw_cnt = 0;
            end
            if (!mem_oe_n) oe_cnt++;
            else if (oe_cnt > 0) begin
                check("R10", "read strobe cycles", oe_cnt, EXP_RD);
                oe_cnt = 0;
            end
            if (!mem_oe_n) begin saw_read = 1; gap = 0; end
            else if (!mem_dq_oe) gap++;
            if (mem_dq_oe && !pdq && saw_read) begin
                check("R9", "quiet cycles before drive", {31'h0, gap >= 1}, 32'h1);
                saw_read = 0;
            end
            prev_idle = &mem_cs_n;
            pa = mem_addr; pws = ws; pdq = mem_dq_oe;
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        for (int k = 0; k < 8; k++)
            for (int j = 0; j < 64; j++) begin
                stub[k][j]  = 8'h00;
                model[k][j] = 8'h00;
            end
        repeat (3) @(negedge clk);
        check("R1", "cs in reset", {24'h0, mem_cs_n}, 32'hFF);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "cs after reset", {24'h0, mem_cs_n}, 32'hFF);
        check("R1", "strobes after reset", {30'h0, mem_we_n, mem_oe_n}, 32'h3);
        check("R1", "drive/ack after reset", {30'h0, mem_dq_oe, host_ack}, 32'h0);

        // R2: 32-bit, both banks
        do_op(1, 2'b10, 22'h000005, 32'h11223344, "R2");
        do_op(1, 2'b10, 22'h080007, 32'hA5B6C7D8, "R2");
        do_op(0, 2'b10, 22'h000005, 32'h0, "R2");
        do_op(0, 2'b10, 22'h080007, 32'h0, "R2");
        // R3: 16-bit, both pairs and bank 1
        do_op(1, 2'b01, 22'h00000A, 32'hFFFF_BEEF, "R3");
        do_op(1, 2'b01, 22'h00000B, 32'h0000_CAFE, "R3");
        do_op(1, 2'b01, 22'h10000C, 32'h0000_1234, "R3");
        do_op(0, 2'b01, 22'h00000A, 32'h0, "R3");
        do_op(0, 2'b01, 22'h00000B, 32'h0, "R3");
        do_op(0, 2'b01, 22'h10000C, 32'h0, "R3");
        do_op(0, 2'b10, 22'h000005, 32'h0, "R6");
        // R4: 8-bit, every lane and bank 1
        for (int l = 0; l < 4; l++)
            do_op(1, 2'b00, 22'h000024 | 22'(l), 32'hFFFFFF10 + 32'(l), "R4");
        do_op(1, 2'b00, 22'h200026, 32'h0000005A, "R4");
        for (int l = 0; l < 4; l++) begin
            do_op(0, 2'b00, 22'h000024 | 22'(l), 32'h0, "R4");
            do_op(1, 2'b00, 22'h000030 | 22'(l), 32'h000000C0 + 32'(l), "R4");
        end
        do_op(0, 2'b00, 22'h200026, 32'h0, "R4");
        do_op(0, 2'b10, 22'h000009, 32'h0, "R6");
        do_op(0, 2'b10, 22'h000009 | 22'h080000, 32'h0, "R6");
        do_op(0, 2'b01, 22'h000019, 32'h0, "R6");

        repeat (4) @(negedge clk);
        check("R7", "address moved under write strobe", viol_addr, 0);
        check("R9", "drive rule breaks", viol_drive, 0);
        check("R11", "open requests", sb.size(), 0);
        summary();
        $finish;
    end

endmodule